// File: doc/BRIEF.md
# Timebase Counter with Reference-Match Interrupts

This block keeps a free-running up-counter, the low word of a timebase, and watches it against two programmable reference values. When the counter steps onto a reference value, a sticky status flag for that source is set. Each source has its own interrupt enable. The interrupt request is driven on one of eight priority lines, and the line is picked by a one-hot level field. Counting depends on a run bit and can be halted by a debug-freeze input when the freeze option is turned on. The same count enable drives a gate output that a neighbouring decrementer uses. A carry pulse marks each wrap of the low word for the upper-word logic.

Software reaches the block through a small register file on a plain strobe bus. The bus has a write strobe, a read strobe, an address, write data and registered read data. Every register write except a write to the key register is blocked until the key register is unlocked. A lock state machine has two states, KL_LOCKED and KL_OPEN:
- Writing the key value while in KL_LOCKED takes the transition to KL_OPEN.
- Writing any other value while in KL_OPEN takes the transition back to KL_LOCKED.
- All other cycles hold the current state.

Reads are allowed at any time.

Register map, with word addresses: 0 control/status, 1 key, 2 reference A, 3 reference B, 4 count (read only).

The control/status word has these fields:
- [7:0] level, one-hot.
- [8] flag A.
- [9] flag B.
- [11:10] reserved.
- [12] interrupt enable A.
- [13] interrupt enable B.
- [14] freeze enable.
- [15] run.

Top module: `tbase_refmatch`

## Requirements
- R1: After reset, every register reads as zero: control/status, key status, both references and the count. In addition, the lock is in KL_LOCKED, and `irq_lines`, `dec_gate` and `tb_carry` are low.
- R2: On every clock edge where the count enable is high, `tb_low` increases by one, modulo 2^CNT_W. `tb_carry` is high in the cycle after the edge that wraps `tb_low` from all ones to zero.
- R3: The count enable equals run (bit 15) and not (freeze enable and `freeze`). `dec_gate` shows the count enable. While the enable is low, `tb_low` holds its value.
- R4: With freeze enable (bit 14) set, a high `freeze` stops the count. With bit 14 clear, `freeze` has no effect on counting.
- R5: Flag A (bit 8) is set on the edge where the counter advances onto reference A. Flag B (bit 9) is set the same way for reference B. A flag stays set until it is cleared.
- R6: An accepted control write with a 1 in bit 8 or bit 9 clears that flag. A 0 in either bit leaves that flag as it was. If a match and a clear of the same flag fall on one edge, the flag stays set.
- R7: `irq_lines` equals the level field when (flag A and enable A) or (flag B and enable B) is true, and is zero otherwise.
- R8: Bits 11:10 of the control/status word always read as zero, whatever was written to them.
- R9: Writes to control/status and to the references take effect only in KL_OPEN. Writing the key value to address 1 unlocks, and writing any other value there locks. Reading address 1 returns 1 in bit 0 when unlocked and 0 otherwise.
- R10: `rdata` is loaded on the edge where `rd_en` is high. It holds the addressed register as it stood before that edge, and the count at address 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hard reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| freeze | input | 1 | Debug freeze request |
| tb_low | output | CNT_W | Low timebase word |
| tb_carry | output | 1 | One-cycle pulse after the low word wraps |
| dec_gate | output | 1 | Count enable shared with the decrementer |
| irq_lines | output | 8 | Interrupt request on the selected priority line |

## Verification
The assertions assume that the two strobes never fire in the same cycle. They also assume that the address is stable only while a strobe is high, and that `freeze` changes only between edges. The bench drives every input from tasks on the falling edge and never raises both strobes together. The flag properties further assume that control writes are the only way to clear a flag. The bench therefore issues each clear as a single control write, including the one that is timed to land on a match edge.

// File: rtl/tbr_pkg.sv
package tbr_pkg;

    localparam int NLVL   = 8;
    localparam int NREF   = 2;
    localparam int CTRL_W = 16;

    localparam int B_LVL  = 0;
    localparam int B_FLAG = 8;
    localparam int B_IEN  = 12;
    localparam int B_FRZ  = 14;
    localparam int B_RUN  = 15;

    localparam int OFS_CTRL = 0;
    localparam int OFS_KEY  = 1;
    localparam int OFS_REF0 = 2;
    localparam int OFS_CNT  = 4;

    typedef enum logic {
        KL_LOCKED = 1'b0,
        KL_OPEN   = 1'b1
    } key_state_e;

endpackage

// File: rtl/tbr_keylock.sv
module tbr_keylock
    import tbr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter logic [DATA_W-1:0] KEY = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] key_val,
    output logic              unlocked
);

    key_state_e state_q;
    key_state_e state_d;
    logic       key_ok;

    always_comb key_ok = (key_val == KEY);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= KL_LOCKED;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KL_LOCKED: if (key_wr && key_ok)  state_d = KL_OPEN;
            KL_OPEN:   if (key_wr && !key_ok) state_d = KL_LOCKED;
            default:   state_d = KL_LOCKED;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            KL_OPEN: unlocked = 1'b1;
            default: unlocked = 1'b0;
        endcase
    end

endmodule

// File: rtl/tbr_counter.sv
module tbr_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_next,
    output logic             carry_q
);

    always_comb cnt_next = count_en ? cnt_q + CNT_W'(1) : cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            carry_q <= 1'b0;
        end else begin
            cnt_q   <= cnt_next;
            carry_q <= count_en & (&cnt_q);
        end
    end

endmodule

// File: rtl/tbr_match.sv
module tbr_match
    import tbr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                       count_en,
    input  logic [CNT_W-1:0]           cnt_next,
    input  logic [NREF-1:0][CNT_W-1:0] refs,
    output logic [NREF-1:0]            hit
);

    for (genvar g = 0; g < NREF; g++) begin : g_cmp
        assign hit[g] = count_en && (cnt_next == refs[g]);
    end

endmodule

// File: rtl/tbr_regs.sv
module tbr_regs
    import tbr_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic                       rd_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic                       unlocked,
    input  logic                       freeze,
    input  logic [CNT_W-1:0]           cnt,
    input  logic [NREF-1:0]            hit,
    output logic                       count_en,
    output logic [NREF-1:0][CNT_W-1:0] refs,
    output logic [NLVL-1:0]            irq_lines,
    output logic [DATA_W-1:0]          rdata,
    output logic [NLVL-1:0]            level_o,
    output logic [NREF-1:0]            flag_o,
    output logic [NREF-1:0]            ien_o,
    output logic                       frz_en_o
);

    localparam logic [ADDR_W-1:0] AD_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] AD_KEY  = ADDR_W'(OFS_KEY);
    localparam logic [ADDR_W-1:0] AD_CNT  = ADDR_W'(OFS_CNT);

    logic [NLVL-1:0]   level_q;
    logic [NREF-1:0]   flag_q;
    logic [NREF-1:0]   flag_d;
    logic [NREF-1:0]   ien_q;
    logic              frz_en_q;
    logic              run_q;
    logic [CNT_W-1:0]  ref_q [NREF];
    logic              wr_ok;
    logic              ctrl_wr;
    logic [NREF-1:0]   clr;
    logic [CTRL_W-1:0] ctrl_word;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;

    always_comb wr_ok   = wr_en & unlocked;
    always_comb ctrl_wr = wr_ok && (addr == AD_CTRL);

    // control fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q  <= '0;
            ien_q    <= '0;
            frz_en_q <= 1'b0;
            run_q    <= 1'b0;
        end else if (ctrl_wr) begin
            level_q  <= wdata[B_LVL +: NLVL];
            ien_q    <= wdata[B_IEN +: NREF];
            frz_en_q <= wdata[B_FRZ];
            run_q    <= wdata[B_RUN];
        end
    end

    // sticky flags: a match on the same edge as a clear keeps the flag set
    always_comb begin
        clr    = ctrl_wr ? wdata[B_FLAG +: NREF] : '0;
        flag_d = (flag_q & ~clr) | hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    // reference registers
    for (genvar g = 0; g < NREF; g++) begin : g_ref
        localparam logic [ADDR_W-1:0] AD_REF = ADDR_W'(OFS_REF0 + g);
        always_ff @(posedge clk) begin
            if (!rst_n)                       ref_q[g] <= '0;
            else if (wr_ok && addr == AD_REF) ref_q[g] <= wdata[CNT_W-1:0];
        end
        assign refs[g] = ref_q[g];
    end

    always_comb count_en = run_q & ~(frz_en_q & freeze);

    always_comb irq_lines = (|(flag_q & ien_q)) ? level_q : '0;

    always_comb begin
        ctrl_word                  = '0;
        ctrl_word[B_LVL +: NLVL]   = level_q;
        ctrl_word[B_FLAG +: NREF]  = flag_q;
        ctrl_word[B_IEN +: NREF]   = ien_q;
        ctrl_word[B_FRZ]           = frz_en_q;
        ctrl_word[B_RUN]           = run_q;
    end

    always_comb begin
        rd_mux = '0;
        if (addr == AD_CTRL) rd_mux = DATA_W'(ctrl_word);
        if (addr == AD_KEY)  rd_mux = DATA_W'(unlocked);
        if (addr == AD_CNT)  rd_mux = DATA_W'(cnt);
        for (int i = 0; i < NREF; i++) begin
            if (addr == ADDR_W'(OFS_REF0 + i)) rd_mux = DATA_W'(ref_q[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_mux;
    end

    assign rdata    = rdata_q;
    assign level_o  = level_q;
    assign flag_o   = flag_q;
    assign ien_o    = ien_q;
    assign frz_en_o = frz_en_q;

endmodule

// File: rtl/tbase_refmatch.sv
module tbase_refmatch
    import tbr_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    parameter logic [DATA_W-1:0] KEY = DATA_W'(32'h5A3C_96E1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              freeze,
    output logic [CNT_W-1:0]  tb_low,
    output logic              tb_carry,
    output logic              dec_gate,
    output logic [NLVL-1:0]   irq_lines
);

    localparam logic [ADDR_W-1:0] AD_KEY = ADDR_W'(OFS_KEY);

    logic                       unlocked_w;
    logic                       count_en_w;
    logic [CNT_W-1:0]           cnt_w;
    logic [CNT_W-1:0]           cnt_next_w;
    logic [NREF-1:0][CNT_W-1:0] refs_w;
    logic [NREF-1:0]            hit_w;
    logic [NLVL-1:0]            level_w;
    logic [NREF-1:0]            flag_w;
    logic [NREF-1:0]            ien_w;
    logic                       frz_en_w;
    logic                       key_wr_w;

    always_comb key_wr_w = wr_en && (addr == AD_KEY);

    tbr_keylock #(.DATA_W(DATA_W), .KEY(KEY)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (key_wr_w),
        .key_val  (wdata),
        .unlocked (unlocked_w)
    );

    tbr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (count_en_w),
        .cnt_q    (cnt_w),
        .cnt_next (cnt_next_w),
        .carry_q  (tb_carry)
    );

    tbr_match #(.CNT_W(CNT_W)) u_match (
        .count_en (count_en_w),
        .cnt_next (cnt_next_w),
        .refs     (refs_w),
        .hit      (hit_w)
    );

    tbr_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wdata     (wdata),
        .unlocked  (unlocked_w),
        .freeze    (freeze),
        .cnt       (cnt_w),
        .hit       (hit_w),
        .count_en  (count_en_w),
        .refs      (refs_w),
        .irq_lines (irq_lines),
        .rdata     (rdata),
        .level_o   (level_w),
        .flag_o    (flag_w),
        .ien_o     (ien_w),
        .frz_en_o  (frz_en_w)
    );

    assign tb_low   = cnt_w;
    assign dec_gate = count_en_w;

endmodule

// File: rtl/tbase_refmatch_chk.sv
module tbase_refmatch_chk
    import tbr_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              freeze,
    input logic [CNT_W-1:0]  tb_low,
    input logic              dec_gate,
    input logic [NLVL-1:0]   irq_lines,
    input logic [NLVL-1:0]   level,
    input logic [NREF-1:0]   flags,
    input logic [NREF-1:0]   ien,
    input logic              frz_en,
    input logic              unlocked
);

    localparam logic [ADDR_W-1:0] AD_CTRL = ADDR_W'(OFS_CTRL);

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_gate |=> (tb_low == CNT_W'($past(tb_low) + CNT_W'(1))));

    // R3
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_gate |=> $stable(tb_low));

    // R4
    freeze_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frz_en && freeze) |-> !dec_gate);

    // R7
    irq_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lines != '0) |-> ((irq_lines == level) && ((flags & ien) != '0)));

    // R6
    flag_a_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[0] && !(wr_en && unlocked && addr == AD_CTRL && wdata[B_FLAG])) |=> flags[0]);

    // R6
    flag_b_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[1] && !(wr_en && unlocked && addr == AD_CTRL && wdata[B_FLAG+1])) |=> flags[1]);

    // R9
    locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !unlocked && addr == AD_CTRL) |=> ($stable(level) && $stable(ien) && $stable(frz_en)));

    // R8
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == AD_CTRL) |=> (rdata[11:10] == 2'b00));

endmodule

bind tbase_refmatch tbase_refmatch_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .freeze    (freeze),
    .tb_low    (tb_low),
    .dec_gate  (dec_gate),
    .irq_lines (irq_lines),
    .level     (level_w),
    .flags     (flag_w),
    .ien       (ien_w),
    .frz_en    (frz_en_w),
    .unlocked  (unlocked_w)
);

// File: tb/tbase_refmatch_tb.sv
module tbase_refmatch_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CW = 8;
    localparam int AW = 3;
    localparam int DW = 32;
    localparam logic [31:0] KEYV = 32'hC3A5_0F96;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          freeze = 1'b0;
    logic [CW-1:0] tb_low;
    logic          tb_carry;
    logic          dec_gate;
    logic [7:0]    irq_lines;

    tbase_refmatch #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .KEY(KEYV)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .freeze(freeze), .tb_low(tb_low),
        .tb_carry(tb_carry), .dec_gate(dec_gate), .irq_lines(irq_lines)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // bench model of the requirements
    logic [CW-1:0] m_cnt, m_ref0, m_ref1;
    logic          m_carry, m_frz, m_run, m_open;
    logic [7:0]    m_level;
    logic [1:0]    m_flag, m_ien;
    logic [31:0]   m_rdata;

    function automatic logic [31:0] m_ctrl();
        return {16'h0, m_run, m_frz, m_ien, 2'b00, m_flag, m_level};
    endfunction

    function automatic logic [31:0] m_read(input logic [AW-1:0] a);
        case (a)
            3'd0: return m_ctrl();
            3'd1: return {31'h0, m_open};
            3'd2: return {24'h0, m_ref0};
            3'd3: return {24'h0, m_ref1};
            3'd4: return {24'h0, m_cnt};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [7:0] m_irq();
        return ((m_flag & m_ien) != 2'b00) ? m_level : 8'h00;
    endfunction

    always @(posedge clk) begin
        logic          en;
        logic [CW-1:0] nx;
        logic [1:0]    hit;
        logic [1:0]    clr;
        logic          wok;
        if (!rst_n) begin
            m_cnt <= '0; m_ref0 <= '0; m_ref1 <= '0; m_carry <= 1'b0;
            m_frz <= 1'b0; m_run <= 1'b0; m_open <= 1'b0; m_level <= '0;
            m_flag <= '0; m_ien <= '0; m_rdata <= '0;
        end else begin
            en     = m_run && !(m_frz && freeze);
            nx     = en ? m_cnt + 8'd1 : m_cnt;
            hit[0] = en && (nx == m_ref0);
            hit[1] = en && (nx == m_ref1);
            wok    = wr_en && m_open;
            clr    = (wok && addr == 3'd0) ? wdata[9:8] : 2'b00;
            if (rd_en) m_rdata <= m_read(addr);
            m_cnt   <= nx;
            m_carry <= en && (m_cnt == 8'hFF);
            m_flag  <= (m_flag & ~clr) | hit;
            if (wok && addr == 3'd0) begin
                m_level <= wdata[7:0];
                m_ien   <= wdata[13:12];
                m_frz   <= wdata[14];
                m_run   <= wdata[15];
            end
            if (wr_en && addr == 3'd1) m_open <= (wdata == KEYV);
            if (wok && addr == 3'd2) m_ref0 <= wdata[7:0];
            if (wok && addr == 3'd3) m_ref1 <= wdata[7:0];
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // per-cycle output checks, away from the rising edge
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            check("R2 tb_low", 32'(tb_low), 32'(m_cnt));
            check("R2 tb_carry", 32'(tb_carry), 32'(m_carry));
            check("R3 dec_gate", 32'(dec_gate), 32'(m_run && !(m_frz && freeze)));
            check("R7 irq_lines", 32'(irq_lines), 32'(m_irq()));
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_up();
    end

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        #2;
        d = rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [AW-1:0] a, output logic [31:0] d);
        rd(a, d);
        check(tag, d, m_rdata);
    endtask

    logic [31:0] d;
    logic [31:0] d2;

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", 32'(irq_lines), 32'h0);
        check("R1 gate", 32'(dec_gate), 32'h0);
        for (int a = 0; a < 5; a++) begin
            rd(AW'(a), d);
            check("R1 reg reset", d, 32'h0);
        end

        // R9 locked write ignored
        wr(3'd0, 32'h0000_8001);
        rd_chk("R9 ctrl locked", 3'd0, d);
        check("R9 ctrl unchanged", d, 32'h0);
        wr(3'd2, 32'h11);
        rd_chk("R9 ref locked", 3'd2, d);
        check("R9 ref unchanged", d, 32'h0);
        wr(3'd1, KEYV ^ 32'h1);
        rd(3'd1, d);
        check("R9 bad key", d, 32'h0);
        wr(3'd1, KEYV);
        rd(3'd1, d);
        check("R9 good key", d, 32'h1);

        // R5 R7 R8 basic match
        wr(3'd2, 32'h10);
        wr(3'd3, 32'h20);
        wr(3'd0, 32'h0000_BC08);
        repeat (40) @(negedge clk);
        rd_chk("R8 ctrl read", 3'd0, d);
        check("R8 reserved zero", {30'h0, d[11:10]}, 32'h0);
        check("R5 both flags", {30'h0, d[9:8]}, 32'h3);
        check("R7 irq level", 32'(irq_lines), 32'h08);

        // R6 W1C
        wr(3'd0, 32'h0000_B108);
        rd(3'd0, d);
        check("R6 clear A only", {30'h0, d[9:8]}, 32'h2);
        wr(3'd0, 32'h0000_B008);
        rd(3'd0, d);
        check("R6 zero keeps B", {30'h0, d[9:8]}, 32'h2);
        wr(3'd0, 32'h0000_1208);
        rd(3'd0, d);
        check("R7 irq off", 32'(irq_lines), 32'h0);
        check("R6 clear B", {30'h0, d[9:8]}, 32'h0);

        // R5 R7 sweep of reference values, levels and enables
        for (int r = 0; r < 256; r++) begin
            logic [31:0] lv;
            logic [31:0] ie;
            lv = 32'h1 << (r % 8);
            ie = 32'(r % 4);
            wr(3'd2, 32'(r));
            wr(3'd3, 32'((r + 128) % 256));
            wr(3'd0, 32'h8300 | (ie << 12) | lv);
            repeat (257) @(negedge clk);
            rd_chk("R5 sweep ctrl", 3'd0, d);
            check("R5 sweep flags", {30'h0, d[9:8]}, 32'h3);
            check("R7 sweep irq", 32'(irq_lines), (ie != 0) ? lv : 32'h0);
        end

        // R6 match and clear on the same edge
        wr(3'd2, 32'h40);
        wr(3'd0, 32'h0000_9301);
        while (m_cnt != 8'h3F) @(negedge clk);
        wr(3'd0, 32'h0000_9101);
        rd(3'd0, d);
        check("R6 set wins", {31'h0, d[8]}, 32'h1);

        // R4 freeze
        wr(3'd0, 32'h0000_C000);
        freeze = 1'b1;
        rd_chk("R10 count read", 3'd4, d);
        repeat (10) @(negedge clk);
        rd_chk("R4 frozen count", 3'd4, d2);
        check("R4 frozen hold", d2, d);
        wr(3'd0, 32'h0000_8000);
        rd(3'd4, d);
        repeat (10) @(negedge clk);
        rd_chk("R4 freeze ignored", 3'd4, d2);
        check("R4 counts on", 32'((d2 - d) % 256), 32'd11);
        freeze = 1'b0;

        // R3 run off
        wr(3'd0, 32'h0000_0000);
        rd(3'd4, d);
        repeat (20) @(negedge clk);
        rd(3'd4, d2);
        check("R3 stopped", d2, d);

        // R9 relock
        wr(3'd1, 32'h0);
        rd(3'd1, d);
        check("R9 relocked", d, 32'h0);
        wr(3'd0, 32'h0000_8000);
        rd_chk("R9 relock write ignored", 3'd0, d);
        check("R9 run still off", {31'h0, d[15]}, 32'h0);

        repeat (3) @(negedge clk);
        finish_up();
    end

endmodule